// File: doc/BRIEF.md
# Display Window Update Sequencer

This block writes a rectangular region of a display controller's memory over a four-wire serial link. The link uses a separate line to mark each byte as a command or as data. A start pulse captures the inputs: the column and row bounds, the pixel format, a flip flag, the panel height, a source base address and a row stride. The block then sends a fixed header of three commands, each with its parameters. After the header it streams every row of the rectangle. It reads the pixel bytes one at a time from an external frame-buffer read port that has a latency of one cycle.

Two pixel formats are supported. Grayscale rows are copied unchanged, two bytes per column unit. RGB rows take 32-bit source pixels and emit three bytes of 6 bits each, dropping the fourth source byte. After reset the block first drives a two-phase reset pulse to the panel and accepts no work until that pulse is complete. The command opcodes are parameters, so the same sequencer can serve controllers that use different opcodes.

The control flow is a single state machine with these states:

- `ST_POR`: the panel reset pulse is in progress.
- `ST_IDLE`: the block is waiting for a start pulse.
- `ST_CMD_ROW`, `ST_ROW_FIRST`, `ST_ROW_LAST`: the row-window command and its two parameters.
- `ST_CMD_COL`, `ST_COL_FIRST`, `ST_COL_LAST`: the column-window command and its two parameters.
- `ST_CMD_RAM`: the memory-write command.
- `ST_FETCH`: the frame-buffer address is presented.
- `ST_LOAD`: the returned byte is captured and converted.
- `ST_PIXEL`: the pixel byte is shifted out.

The transitions are:

- `ST_POR` moves to `ST_IDLE` when the reset timer finishes.
- `ST_IDLE` moves to `ST_CMD_ROW` on start.
- Each header state moves to the next one when its byte completes, and `ST_CMD_RAM` moves to `ST_FETCH`.
- `ST_FETCH` always moves to `ST_LOAD`, and `ST_LOAD` always moves to `ST_PIXEL`.
- When its byte completes, `ST_PIXEL` returns to `ST_FETCH`, or moves to `ST_IDLE` after the last byte of the last row.

Top module: `dwin_seq`

## Requirements
- R1: After reset, `lcd_rst_n` is held low for RST_CYCLES clocks, then held high for RST_CYCLES clocks. `busy` stays high throughout this sequence and falls at most two clocks after the high phase ends. Once `lcd_rst_n` has risen, it stays high until the next reset.
- R2: The serial link runs in mode 0. SCLK idles low and is low whenever `spi_cs_n` is high. Bits are sent MSB first, and MOSI and `spi_dc` are stable at every rising SCLK. `spi_dc` is 0 for command bytes and 1 for parameter and pixel bytes, and it settles at least DIV clocks before the first rising SCLK of its byte.
- R3: The header is sent in this order: OP_ROW, first row, last row, OP_COL, first column, last column, OP_RAM. The three opcodes are parameters.
- R4: Rows are sent from the first row to the last row inclusive, and no further bytes follow. Row k (counting from 0) is read starting at `src_base + k*src_stride`.
- R5: In grayscale mode (`pix_mode` = 0), each row carries (last column + 1 − first column) × 2 bytes, capped at MAX_GRAY_BYTES. These bytes are read from consecutive addresses starting at the row base and are sent unchanged.
- R6: In RGB mode (`pix_mode` = 1), pixel p of a row produces three bytes. Each byte is read from row base + 4p + c, for c = 0, 1, 2, and is sent as the source byte shifted right by 2. Offset +3 is never sent. A row holds at most MAX_RGB_PIX pixels.
- R7: In RGB mode with `flip` = 1, both row parameters are sent increased by (FLIP_SPAN − `panel_height`), modulo 256. In grayscale mode the flip flag has no effect. The row loop and the row addresses always use the unshifted bounds.
- R8: `busy` rises in the clock after a start is accepted. It falls together with a one-clock `done` pulse after the last pixel byte has shifted out. `spi_cs_n` is low only while `busy` is high.
- R9: A start pulse during the reset sequence or during a transfer is ignored. Inputs that change after the start is accepted do not affect the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, sampled in idle |
| pix_mode | input | 1 | 0 = grayscale, 1 = RGB |
| flip | input | 1 | Panel mounted upside down |
| col_first | input | 8 | First column of the window |
| col_last | input | 8 | Last column of the window |
| row_first | input | 8 | First row of the window |
| row_last | input | 8 | Last row of the window |
| panel_height | input | 8 | Visible panel rows, used for the flip offset |
| src_base | input | ADDR_W | Frame-buffer address of the first row |
| src_stride | input | ADDR_W | Address step between rows |
| fb_addr | output | ADDR_W | Frame-buffer read address |
| fb_rd | output | 1 | Frame-buffer read strobe |
| fb_data | input | 8 | Read data, valid one clock after the address |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_dc | output | 1 | Command (0) or data (1) marker |
| spi_cs_n | output | 1 | Chip select, active low |
| lcd_rst_n | output | 1 | Panel reset, active low |
| busy | output | 1 | Reset sequence or transfer in progress |
| done | output | 1 | One-clock pulse when a transfer ends |

## Verification
The bench runs several transfers, and each one separates a different part of the behaviour:

- A multi-row grayscale window with a nonzero stride shows whether the row stepping and the stride are correct.
- A two-pixel RGB window shows whether the alpha byte is skipped and whether each channel is shifted.
- A flipped RGB window and a flipped grayscale window together show that the row offset applies only in RGB mode.
- A grayscale window wider than the cap shows that the row length is clamped.
- A start pulse, together with new input values, arrives partway through one transfer and again during the reset pulse. The byte stream is expected to stay unchanged in both cases.

// File: rtl/dwin_pkg.sv
`timescale 1ns/1ps
package dwin_pkg;

    typedef enum logic [3:0] {
        ST_POR,
        ST_IDLE,
        ST_CMD_ROW,
        ST_ROW_FIRST,
        ST_ROW_LAST,
        ST_CMD_COL,
        ST_COL_FIRST,
        ST_COL_LAST,
        ST_CMD_RAM,
        ST_FETCH,
        ST_LOAD,
        ST_PIXEL
    } seq_state_t;

    typedef enum logic {
        PIX_GRAY = 1'b0,
        PIX_RGB  = 1'b1
    } pix_mode_t;

endpackage

// File: rtl/dwin_por.sv
`timescale 1ns/1ps
module dwin_por #(
    parameter int RST_CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    output logic lcd_rst_n,
    output logic ready
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

    typedef enum logic [1:0] {PH_LOW, PH_HIGH, PH_READY} por_phase_t;

    por_phase_t     phase;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_LOW;
            cnt   <= '0;
        end else if (phase != PH_READY) begin
            if (cnt == LAST) begin
                cnt   <= '0;
                phase <= (phase == PH_LOW) ? PH_HIGH : PH_READY;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign lcd_rst_n = (phase != PH_LOW);
    assign ready     = (phase == PH_READY);

endmodule

// File: rtl/dwin_spi_tx.sv
`timescale 1ns/1ps
module dwin_spi_tx #(
    parameter int DIV = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] byte_in,
    input  logic       dc_in,
    output logic       fin,
    output logic       sclk,
    output logic       mosi,
    output logic       dc
);
    localparam int DW = $clog2(DIV + 1);
    localparam logic [DW-1:0] TICK_LAST = DW'(DIV - 1);

    logic          active;
    logic [DW-1:0] tick;
    logic [2:0]    bitn;
    logic [7:0]    sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            tick   <= '0;
            bitn   <= '0;
            sh     <= '0;
            sclk   <= 1'b0;
            dc     <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    sh     <= byte_in;
                    dc     <= dc_in;
                    tick   <= '0;
                    bitn   <= '0;
                    sclk   <= 1'b0;
                end
            end else if (tick == TICK_LAST) begin
                tick <= '0;
                if (!sclk) begin
                    sclk <= 1'b1;
                end else begin
                    sclk <= 1'b0;
                    if (bitn == 3'd7) begin
                        active <= 1'b0;
                        fin    <= 1'b1;
                    end else begin
                        bitn <= bitn + 3'd1;
                        sh   <= {sh[6:0], 1'b0};
                    end
                end
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

    assign mosi = sh[7];

endmodule

// File: rtl/dwin_geom.sv
`timescale 1ns/1ps
module dwin_geom
    import dwin_pkg::*;
#(
    parameter int MAX_GRAY_BYTES = 128,
    parameter int MAX_RGB_PIX    = 160,
    parameter int FLIP_SPAN      = 132,
    parameter int LEN_W          = 9
) (
    input  pix_mode_t        mode,
    input  logic             flip,
    input  logic [7:0]       col_first,
    input  logic [7:0]       col_last,
    input  logic [7:0]       row_first,
    input  logic [7:0]       row_last,
    input  logic [7:0]       panel_height,
    output logic [LEN_W-1:0] row_len,
    output logic [7:0]       row_par_first,
    output logic [7:0]       row_par_last
);
    localparam int XW = LEN_W + 2;

    logic [8:0]    units;
    logic [8:0]    rgb_pix;
    logic [XW-1:0] gray_len;
    logic [XW-1:0] rgb_len;
    logic [7:0]    shift;

    always_comb begin
        units    = {1'b0, col_last} - {1'b0, col_first} + 9'd1;
        gray_len = XW'(units) << 1;
        if (gray_len > XW'(MAX_GRAY_BYTES)) begin
            gray_len = XW'(MAX_GRAY_BYTES);
        end
        rgb_pix  = (units > 9'(MAX_RGB_PIX)) ? 9'(MAX_RGB_PIX) : units;
        rgb_len  = XW'(rgb_pix) * XW'(3);
        row_len  = (mode == PIX_RGB) ? rgb_len[LEN_W-1:0] : gray_len[LEN_W-1:0];
        shift    = (mode == PIX_RGB && flip) ? (8'(FLIP_SPAN) - panel_height) : 8'h00;
        row_par_first = row_first + shift;
        row_par_last  = row_last + shift;
    end

endmodule

// File: rtl/dwin_seq.sv
`timescale 1ns/1ps
module dwin_seq
    import dwin_pkg::*;
#(
    parameter int         ADDR_W         = 16,
    parameter int         DIV            = 10,
    parameter int         RST_CYCLES     = 20000,
    parameter logic [7:0] OP_ROW         = 8'h75,
    parameter logic [7:0] OP_COL         = 8'h15,
    parameter logic [7:0] OP_RAM         = 8'h5C,
    parameter int         MAX_GRAY_BYTES = 128,
    parameter int         MAX_RGB_PIX    = 160,
    parameter int         FLIP_SPAN      = 132
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pix_mode,
    input  logic              flip,
    input  logic [7:0]        col_first,
    input  logic [7:0]        col_last,
    input  logic [7:0]        row_first,
    input  logic [7:0]        row_last,
    input  logic [7:0]        panel_height,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] src_stride,
    output logic [ADDR_W-1:0] fb_addr,
    output logic              fb_rd,
    input  logic [7:0]        fb_data,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic              spi_dc,
    output logic              spi_cs_n,
    output logic              lcd_rst_n,
    output logic              busy,
    output logic              done
);
    localparam int MAX_LEN = (MAX_GRAY_BYTES > 3 * MAX_RGB_PIX) ? MAX_GRAY_BYTES : 3 * MAX_RGB_PIX;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    seq_state_t        state, state_n;
    logic              launched;
    logic              tx_go, tx_dc, tx_fin;
    logic [7:0]        tx_byte;
    logic              por_ready;

    pix_mode_t         m_mode;
    logic              m_flip;
    logic [7:0]        m_cf, m_cl, m_rf, m_rl, m_ph;
    logic [ADDR_W-1:0] m_stride;
    logic [ADDR_W-1:0] row_base;
    logic [ADDR_W-1:0] src_off;
    logic [7:0]        row_cur;
    logic [LEN_W-1:0]  byte_cnt;
    logic [1:0]        chan;
    logic [7:0]        pix_byte;

    logic [LEN_W-1:0]  row_len;
    logic [7:0]        row_par_first, row_par_last;
    logic              last_byte, last_row, accept;

    dwin_por #(.RST_CYCLES(RST_CYCLES)) u_por (
        .clk       (clk),
        .rst_n     (rst_n),
        .lcd_rst_n (lcd_rst_n),
        .ready     (por_ready)
    );

    dwin_spi_tx #(.DIV(DIV)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (tx_go),
        .byte_in (tx_byte),
        .dc_in   (tx_dc),
        .fin     (tx_fin),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .dc      (spi_dc)
    );

    dwin_geom #(
        .MAX_GRAY_BYTES (MAX_GRAY_BYTES),
        .MAX_RGB_PIX    (MAX_RGB_PIX),
        .FLIP_SPAN      (FLIP_SPAN),
        .LEN_W          (LEN_W)
    ) u_geom (
        .mode          (m_mode),
        .flip          (m_flip),
        .col_first     (m_cf),
        .col_last      (m_cl),
        .row_first     (m_rf),
        .row_last      (m_rl),
        .panel_height  (m_ph),
        .row_len       (row_len),
        .row_par_first (row_par_first),
        .row_par_last  (row_par_last)
    );

    assign last_byte = (byte_cnt == row_len - LEN_W'(1));
    assign last_row  = (row_cur == m_rl);
    assign accept    = (state == ST_IDLE) && start;
    assign fb_addr   = row_base + src_off;
    assign fb_rd     = (state == ST_FETCH);

    // Next state and byte selection
    always_comb begin
        state_n = state;
        tx_go   = 1'b0;
        tx_byte = 8'h00;
        tx_dc   = 1'b1;
        unique case (state)
            ST_POR: begin
                if (por_ready) state_n = ST_IDLE;
            end
            ST_IDLE: begin
                if (start) state_n = ST_CMD_ROW;
            end
            ST_CMD_ROW: begin
                tx_byte = OP_ROW;
                tx_dc   = 1'b0;
                tx_go   = !launched;
                if (tx_fin) state_n = ST_ROW_FIRST;
            end
            ST_ROW_FIRST: begin
                tx_byte = row_par_first;
                tx_go   = !launched;
                if (tx_fin) state_n = ST_ROW_LAST;
            end
            ST_ROW_LAST: begin
                tx_byte = row_par_last;
                tx_go   = !launched;
                if (tx_fin) state_n = ST_CMD_COL;
            end
            ST_CMD_COL: begin
                tx_byte = OP_COL;
                tx_dc   = 1'b0;
                tx_go   = !launched;
                if (tx_fin) state_n = ST_COL_FIRST;
            end
            ST_COL_FIRST: begin
                tx_byte = m_cf;
                tx_go   = !launched;
                if (tx_fin) state_n = ST_COL_LAST;
            end
            ST_COL_LAST: begin
                tx_byte = m_cl;
                tx_go   = !launched;
                if (tx_fin) state_n = ST_CMD_RAM;
            end
            ST_CMD_RAM: begin
                tx_byte = OP_RAM;
                tx_dc   = 1'b0;
                tx_go   = !launched;
                if (tx_fin) state_n = ST_FETCH;
            end
            ST_FETCH: begin
                state_n = ST_LOAD;
            end
            ST_LOAD: begin
                state_n = ST_PIXEL;
            end
            ST_PIXEL: begin
                tx_byte = pix_byte;
                tx_go   = !launched;
                if (tx_fin) state_n = (last_byte && last_row) ? ST_IDLE : ST_FETCH;
            end
            default: begin
                state_n = ST_POR;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_POR;
            launched <= 1'b0;
        end else begin
            state <= state_n;
            if (tx_fin) begin
                launched <= 1'b0;
            end else if (tx_go) begin
                launched <= 1'b1;
            end
        end
    end

    // Captured request and pixel walk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode   <= PIX_GRAY;
            m_flip   <= 1'b0;
            m_cf     <= '0;
            m_cl     <= '0;
            m_rf     <= '0;
            m_rl     <= '0;
            m_ph     <= '0;
            m_stride <= '0;
            row_base <= '0;
            src_off  <= '0;
            row_cur  <= '0;
            byte_cnt <= '0;
            chan     <= '0;
            pix_byte <= '0;
        end else if (accept) begin
            m_mode   <= pix_mode_t'(pix_mode);
            m_flip   <= flip;
            m_cf     <= col_first;
            m_cl     <= col_last;
            m_rf     <= row_first;
            m_rl     <= row_last;
            m_ph     <= panel_height;
            m_stride <= src_stride;
            row_base <= src_base;
            row_cur  <= row_first;
            src_off  <= '0;
            byte_cnt <= '0;
            chan     <= '0;
        end else if (state == ST_LOAD) begin
            pix_byte <= (m_mode == PIX_RGB) ? {2'b00, fb_data[7:2]} : fb_data;
        end else if (state == ST_PIXEL && tx_fin) begin
            if (last_byte) begin
                byte_cnt <= '0;
                src_off  <= '0;
                chan     <= '0;
                row_base <= row_base + m_stride;
                row_cur  <= row_cur + 8'd1;
            end else begin
                byte_cnt <= byte_cnt + LEN_W'(1);
                if (m_mode == PIX_RGB && chan == 2'd2) begin
                    chan    <= '0;
                    src_off <= src_off + ADDR_W'(2);
                end else begin
                    chan    <= (m_mode == PIX_RGB) ? chan + 2'd1 : 2'd0;
                    src_off <= src_off + ADDR_W'(1);
                end
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy     <= 1'b1;
            done     <= 1'b0;
            spi_cs_n <= 1'b1;
        end else begin
            busy     <= (state_n != ST_IDLE);
            done     <= (state == ST_PIXEL) && (state_n == ST_IDLE);
            spi_cs_n <= (state_n == ST_IDLE) || (state_n == ST_POR);
        end
    end

endmodule

// File: rtl/dwin_seq_chk.sv
`timescale 1ns/1ps
module dwin_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_dc,
    input logic spi_cs_n,
    input logic lcd_rst_n,
    input logic busy,
    input logic done,
    input logic fb_rd
);
    // R2
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R2
    dc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> $stable(spi_dc));

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> $stable(spi_mosi));

    // R1
    rst_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rst_n |-> busy);

    // R1
    rst_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_rst_n |=> lcd_rst_n);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

    // R4
    read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rd |-> (busy && lcd_rst_n));

endmodule

bind dwin_seq dwin_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_dc    (spi_dc),
    .spi_cs_n  (spi_cs_n),
    .lcd_rst_n (lcd_rst_n),
    .busy      (busy),
    .done      (done),
    .fb_rd     (fb_rd)
);

// File: tb/dwin_seq_tb.sv
`timescale 1ns/1ps
module dwin_seq_tb;
    localparam int         ADDR_W = 16;
    localparam int         DIV    = 2;
    localparam int         RST    = 40;
    localparam logic [7:0] OP_ROW = 8'h75;
    localparam logic [7:0] OP_COL = 8'h15;
    localparam logic [7:0] OP_RAM = 8'h5C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              pix_mode = 1'b0;
    logic              flip = 1'b0;
    logic [7:0]        col_first = '0, col_last = '0, row_first = '0, row_last = '0, panel_height = '0;
    logic [ADDR_W-1:0] src_base = '0, src_stride = '0;
    logic [ADDR_W-1:0] fb_addr;
    logic              fb_rd;
    logic [7:0]        fb_data = '0;
    logic              spi_sclk, spi_mosi, spi_dc, spi_cs_n, lcd_rst_n, busy, done;

    always #2.5 clk = ~clk;

    dwin_seq #(
        .ADDR_W(ADDR_W), .DIV(DIV), .RST_CYCLES(RST),
        .OP_ROW(OP_ROW), .OP_COL(OP_COL), .OP_RAM(OP_RAM)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pix_mode(pix_mode), .flip(flip),
        .col_first(col_first), .col_last(col_last), .row_first(row_first), .row_last(row_last),
        .panel_height(panel_height), .src_base(src_base), .src_stride(src_stride),
        .fb_addr(fb_addr), .fb_rd(fb_rd), .fb_data(fb_data),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_dc(spi_dc), .spi_cs_n(spi_cs_n),
        .lcd_rst_n(lcd_rst_n), .busy(busy), .done(done)
    );

    function automatic logic [7:0] fb_fn(input logic [15:0] a);
        return (a[7:0] ^ {a[12:8], 3'b101}) + 8'h5B;
    endfunction

    always @(posedge clk) fb_data <= fb_fn(fb_addr);

    int n_chk = 0, n_fail = 0, n_bytes = 0;
    bit finished = 0;
    logic [8:0] q_val[$];
    string      q_tag[$];

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic dc, input int b, input string tag);
        q_val.push_back({dc, 8'(b)});
        q_tag.push_back(tag);
    endtask

    // Monitor: rebuild bytes from the serial link and compare with the scoreboard
    logic       sclk_prev = 1'b0, dc_prev = 1'b0, dc_b = 1'b0;
    logic [7:0] shv = '0;
    logic [8:0] exp_v;
    string      exp_t;
    int         dc_age = 0, bitc = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            bitc = 0;
            sclk_prev = 1'b0;
            dc_age = 0;
        end else begin
            if (spi_dc !== dc_prev) dc_age = 0;
            else dc_age++;
            if (spi_sclk && !sclk_prev) begin
                if (bitc == 0) begin
                    dc_b = spi_dc;
                    chk(dc_age >= DIV, "R2", "dc settle clocks before first edge", dc_age, DIV);
                    chk(spi_cs_n == 1'b0, "R2", "cs_n low while clocking", int'(spi_cs_n), 0);
                end else if (spi_dc !== dc_b) begin
                    chk(1'b0, "R2", "dc changed inside byte", int'(spi_dc), int'(dc_b));
                end
                shv = {shv[6:0], spi_mosi};
                bitc++;
                if (bitc == 8) begin
                    bitc = 0;
                    n_bytes++;
                    if (q_val.size() == 0) begin
                        chk(1'b0, "R4", "unexpected extra byte", int'({dc_b, shv}), 0);
                    end else begin
                        exp_v = q_val.pop_front();
                        exp_t = q_tag.pop_front();
                        chk({dc_b, shv} == exp_v, exp_t, "byte {dc,data}", int'({dc_b, shv}), int'(exp_v));
                    end
                end
            end
            sclk_prev = spi_sclk;
        end
        dc_prev = spi_dc;
    end

    // Driver: queue the expected stream, launch, then wait for completion
    task automatic run_xfer(input bit rgb, input bit flp, input int cf, input int cl,
                            input int rf, input int rl, input int ph,
                            input int base, input int stride, input bit poke);
        int shift, units, len, rowb;
        string ptag;
        shift = (rgb && flp) ? (132 - ph) : 0;
        ptag  = (rgb && flp) ? "R7" : "R3";
        push(1'b0, OP_ROW, "R3");
        push(1'b1, (rf + shift) & 255, ptag);
        push(1'b1, (rl + shift) & 255, ptag);
        push(1'b0, OP_COL, "R3");
        push(1'b1, cf, "R3");
        push(1'b1, cl, "R3");
        push(1'b0, OP_RAM, "R3");
        for (int r = rf; r <= rl; r++) begin
            rowb = base + (r - rf) * stride;
            if (rgb) begin
                units = cl + 1 - cf;
                if (units > 160) units = 160;
                for (int p = 0; p < units; p++)
                    for (int c = 0; c < 3; c++)
                        push(1'b1, int'(fb_fn(16'(rowb + 4 * p + c)) >> 2), "R6");
            end else begin
                len = (cl + 1 - cf) * 2;
                if (len > 128) len = 128;
                for (int j = 0; j < len; j++)
                    push(1'b1, int'(fb_fn(16'(rowb + j))), "R5");
            end
        end
        @(negedge clk);
        pix_mode = rgb; flip = flp;
        col_first = 8'(cf); col_last = 8'(cl); row_first = 8'(rf); row_last = 8'(rl);
        panel_height = 8'(ph); src_base = 16'(base); src_stride = 16'(stride);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8", "busy after accepted start", int'(busy), 1);
        if (poke) begin
            repeat (150) @(negedge clk);
            col_first = 8'hAA; row_first = 8'h33; pix_mode = ~pix_mode; src_base = 16'h0777;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R9", "still busy after ignored start", int'(busy), 1);
        end
        while (done !== 1'b1) @(negedge clk);
        chk(busy == 1'b0, "R8", "busy low with done", int'(busy), 0);
        chk(q_val.size() == 0, "R4", "expected bytes left at done", q_val.size(), 0);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done lasts one clock", int'(done), 0);
        repeat (20) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R8", "cs_n high when idle", int'(spi_cs_n), 1);
        chk(q_val.size() == 0, "R4", "no trailing bytes", q_val.size(), 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        chk(lcd_rst_n == 1'b0, "R1", "panel reset low in reset", int'(lcd_rst_n), 0);
        chk(busy == 1'b1, "R1", "busy in reset", int'(busy), 1);
        chk(spi_cs_n == 1'b1, "R2", "cs_n high in reset", int'(spi_cs_n), 1);
        chk(done == 1'b0, "R8", "done low in reset", int'(done), 0);
        rst_n = 1'b1;
        cnt = 0;
        while (lcd_rst_n == 1'b0) begin @(negedge clk); cnt++; end
        chk(cnt >= RST && cnt <= RST + 1, "R1", "low phase clocks", cnt, RST);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        while (busy == 1'b1) begin @(negedge clk); cnt++; end
        chk(cnt >= RST && cnt <= RST + 2, "R1", "high phase clocks", cnt, RST);
        repeat (40) @(negedge clk);
        chk(n_bytes == 0, "R9", "start during reset pulse ignored", n_bytes, 0);
        chk(spi_cs_n == 1'b1, "R9", "no transfer after ignored start", int'(spi_cs_n), 1);

        // Multi-row grayscale with stride, plus a start pulse mid-transfer
        run_xfer(1'b0, 1'b0, 2, 4, 5, 7, 0, 'h100, 'h40, 1'b1);
        // RGB, two pixels per row, two rows
        run_xfer(1'b1, 1'b0, 0, 1, 3, 4, 0, 'h200, 'h20, 1'b0);
        // RGB flipped: row parameters shifted by 4
        run_xfer(1'b1, 1'b1, 7, 7, 10, 10, 128, 'h300, 0, 1'b0);
        // Grayscale with flip set: no shift
        run_xfer(1'b0, 1'b1, 9, 9, 20, 21, 100, 'h040, 'h10, 1'b0);
        // Grayscale row longer than the cap
        run_xfer(1'b0, 1'b0, 0, 99, 0, 0, 0, 'h500, 0, 1'b0);
        summary();
    end

endmodule